// File: doc/BRIEF.md
# Scanout Mode Decoder

This block takes the raw display control settings (enable bit, colour depth, visible resolution, virtual line width, panning offsets, byte-order flag) and the size of video memory. It turns them into a checked scanout geometry: bytes per pixel, a pixel format code, visible size, line pitch in bytes, the first byte of the panned window and the window's byte length. A pixel fetch engine and a timing generator read the result. They use it only while the valid flag is high.

The decode passes through one register stage. The outputs show the inputs sampled at the previous clock edge. When the settings stop forming a usable mode, the valid flag drops and the geometry outputs keep the last accepted mode. Each time a new accepted mode differs from the one held, a one-cycle pulse tells consumers to rebuild their view. All pins are plain level signals. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `fb_mode_decoder`

## Requirements
- R1: With `ctl_enable` low, `mode_valid` is low on the cycle after the sampling edge.
- R2: A depth setting of 16 gives `bytes_pp` = 2 and `pix_fmt` = 1 (RGB565), whatever `fb_big_endian` holds.
- R3: A depth setting of 32 gives `bytes_pp` = 4 and `pix_fmt` = 2 (xRGB8888 little-endian) when `fb_big_endian` is 0, or 3 (xRGB8888 big-endian) when it is 1.
- R4: Any depth setting other than 16 or 32 makes the mode invalid.
- R5: The line width used is the larger of `virt_width` and `x_res`. `line_stride` is that width times `bytes_pp`.
- R6: `total_size` = `line_stride` * `y_res`, and `start_offset` = `x_pan` * `bytes_pp` + `y_pan` * `line_stride`. Both are computed at `ADDR_W` bits without overflow.
- R7: A mode with `x_res` or `y_res` below `MIN_DIM` (64) is invalid.
- R8: A mode with `start_offset` + `total_size` greater than `vmem_bytes` is invalid. Exact equality is accepted.
- R9: Every output is registered: it changes only at a clock edge and reflects the inputs sampled there. Reset clears every output to zero.
- R10: `mode_changed` is high for exactly one cycle when an accepted mode differs in any output field from the held mode. Holding the same settings gives no further pulse.
- R11: An invalid mode never pulses `mode_changed` and leaves `bytes_pp`, `pix_fmt`, `width`, `height`, `line_stride`, `start_offset` and `total_size` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_enable | input | 1 | Display enable setting |
| bpp | input | 16 | Colour depth setting in bits per pixel |
| x_res | input | DIM_W | Visible width in pixels |
| y_res | input | DIM_W | Visible height in lines |
| virt_width | input | DIM_W | Virtual line width in pixels |
| x_pan | input | DIM_W | Horizontal pan in pixels |
| y_pan | input | DIM_W | Vertical pan in lines |
| fb_big_endian | input | 1 | Byte order for 32-bit pixels |
| vmem_bytes | input | ADDR_W | Video memory size in bytes |
| mode_valid | output | 1 | Current settings form a usable mode |
| bytes_pp | output | 3 | Bytes per pixel of held mode |
| pix_fmt | output | 2 | Format code of held mode (0 none, 1 RGB565, 2 xRGB LE, 3 xRGB BE) |
| width | output | DIM_W | Visible width of held mode |
| height | output | DIM_W | Visible height of held mode |
| line_stride | output | DIM_W+2 | Line pitch in bytes |
| start_offset | output | ADDR_W | Byte address of the panned window |
| total_size | output | ADDR_W | Byte length of the window |
| mode_changed | output | 1 | One-cycle pulse on acceptance of a different mode |

## Verification
The bench aims at the edges of each rejection rule: resolutions of 63 and 64, a window that ends exactly at the top of memory and one byte past it, and virtual widths just below and just above the visible width. A design with an off-by-one compare would reject a legal 64-line mode or accept a window one byte past memory. A design that skipped the clamp would give a pitch that is too short. Held settings and returns to an earlier mode check the change pulse: a decoder that compared against the raw inputs, and not the held mode, would pulse repeatedly or miss a return. A 16-bit mode with the byte-order flag toggled shows whether the flag leaks into the 16-bit format.

// File: rtl/fbm_pkg.sv
`timescale 1ns/1ps
package fbm_pkg;
  typedef enum logic [1:0] {
    FMT_NONE    = 2'd0,
    FMT_RGB565  = 2'd1,
    FMT_XRGB_LE = 2'd2,
    FMT_XRGB_BE = 2'd3
  } pix_fmt_e;
endpackage

// File: rtl/fbm_format_sel.sv
`timescale 1ns/1ps
module fbm_format_sel #(
  parameter int BPP_W = 16
) (
  input  logic [BPP_W-1:0]  depth,
  input  logic              big_endian,
  output logic              fmt_ok,
  output logic [1:0]        px_shift,
  output logic [2:0]        px_bytes,
  output fbm_pkg::pix_fmt_e fmt
);
  import fbm_pkg::*;

  localparam logic [BPP_W-1:0] DEPTH16 = BPP_W'(16);
  localparam logic [BPP_W-1:0] DEPTH32 = BPP_W'(32);

  always_comb begin
    fmt_ok   = 1'b0;
    px_shift = 2'd0;
    px_bytes = 3'd0;
    fmt      = FMT_NONE;
    if (depth == DEPTH16) begin
      // 16-bit pixels have one layout only; byte order is not consulted
      fmt_ok   = 1'b1;
      px_shift = 2'd1;
      px_bytes = 3'd2;
      fmt      = FMT_RGB565;
    end else if (depth == DEPTH32) begin
      fmt_ok   = 1'b1;
      px_shift = 2'd2;
      px_bytes = 3'd4;
      fmt      = big_endian ? FMT_XRGB_BE : FMT_XRGB_LE;
    end
  end
endmodule

// File: rtl/fbm_geometry.sv
`timescale 1ns/1ps
module fbm_geometry #(
  parameter int DIM_W    = 16,
  parameter int STRIDE_W = DIM_W + 2,
  parameter int ADDR_W   = 40
) (
  input  logic [DIM_W-1:0]    xres,
  input  logic [DIM_W-1:0]    yres,
  input  logic [DIM_W-1:0]    vwidth,
  input  logic [DIM_W-1:0]    xpan,
  input  logic [DIM_W-1:0]    ypan,
  input  logic [1:0]          px_shift,
  output logic [STRIDE_W-1:0] stride,
  output logic [ADDR_W-1:0]   offset,
  output logic [ADDR_W-1:0]   size
);
  logic [DIM_W-1:0]  eff_w;
  logic [ADDR_W-1:0] stride_w;
  logic [ADDR_W-1:0] col_bytes;
  logic [ADDR_W-1:0] row_bytes;

  always_comb begin
    // clamp the line width up to the visible width
    eff_w     = (vwidth < xres) ? xres : vwidth;
    stride    = STRIDE_W'(eff_w) << px_shift;
    stride_w  = ADDR_W'(stride);
    size      = stride_w * ADDR_W'(yres);
    col_bytes = ADDR_W'(xpan) << px_shift;
    row_bytes = stride_w * ADDR_W'(ypan);
    offset    = col_bytes + row_bytes;
  end
endmodule

// File: rtl/fbm_bounds.sv
`timescale 1ns/1ps
module fbm_bounds #(
  parameter int DIM_W   = 16,
  parameter int ADDR_W  = 40,
  parameter int MIN_DIM = 64
) (
  input  logic [DIM_W-1:0]  xres,
  input  logic [DIM_W-1:0]  yres,
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] size,
  input  logic [ADDR_W-1:0] vmem,
  output logic              fits
);
  localparam logic [DIM_W-1:0] MIN_V = DIM_W'(MIN_DIM);

  logic [ADDR_W:0] win_end;
  logic            big_enough;
  logic            in_mem;

  always_comb begin
    win_end    = {1'b0, offset} + {1'b0, size};
    big_enough = (xres >= MIN_V) && (yres >= MIN_V);
    in_mem     = win_end <= {1'b0, vmem};
    fits       = big_enough && in_mem;
  end
endmodule

// File: rtl/fb_mode_decoder.sv
`timescale 1ns/1ps
module fb_mode_decoder #(
  parameter int DIM_W   = 16,
  parameter int ADDR_W  = 40,
  parameter int MIN_DIM = 64,
  parameter int BPP_W   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_enable,
  input  logic [BPP_W-1:0]     bpp,
  input  logic [DIM_W-1:0]     x_res,
  input  logic [DIM_W-1:0]     y_res,
  input  logic [DIM_W-1:0]     virt_width,
  input  logic [DIM_W-1:0]     x_pan,
  input  logic [DIM_W-1:0]     y_pan,
  input  logic                 fb_big_endian,
  input  logic [ADDR_W-1:0]    vmem_bytes,
  output logic                 mode_valid,
  output logic [2:0]           bytes_pp,
  output logic [1:0]           pix_fmt,
  output logic [DIM_W-1:0]     width,
  output logic [DIM_W-1:0]     height,
  output logic [DIM_W+1:0]     line_stride,
  output logic [ADDR_W-1:0]    start_offset,
  output logic [ADDR_W-1:0]    total_size,
  output logic                 mode_changed
);
  import fbm_pkg::*;

  localparam int STRIDE_W = DIM_W + 2;

  logic                fmt_ok;
  logic [1:0]          px_shift;
  logic [2:0]          c_bytes;
  pix_fmt_e            c_fmt;
  logic [STRIDE_W-1:0] c_stride;
  logic [ADDR_W-1:0]   c_offset;
  logic [ADDR_W-1:0]   c_size;
  logic                fits;
  logic                c_valid;
  logic                c_differs;

  fbm_format_sel #(.BPP_W(BPP_W)) u_fmt (
    .depth      (bpp),
    .big_endian (fb_big_endian),
    .fmt_ok     (fmt_ok),
    .px_shift   (px_shift),
    .px_bytes   (c_bytes),
    .fmt        (c_fmt)
  );

  fbm_geometry #(.DIM_W(DIM_W), .STRIDE_W(STRIDE_W), .ADDR_W(ADDR_W)) u_geom (
    .xres     (x_res),
    .yres     (y_res),
    .vwidth   (virt_width),
    .xpan     (x_pan),
    .ypan     (y_pan),
    .px_shift (px_shift),
    .stride   (c_stride),
    .offset   (c_offset),
    .size     (c_size)
  );

  fbm_bounds #(.DIM_W(DIM_W), .ADDR_W(ADDR_W), .MIN_DIM(MIN_DIM)) u_bnd (
    .xres   (x_res),
    .yres   (y_res),
    .offset (c_offset),
    .size   (c_size),
    .vmem   (vmem_bytes),
    .fits   (fits)
  );

  always_comb begin
    c_valid   = ctl_enable && fmt_ok && fits;
    c_differs = (c_bytes     != bytes_pp)     ||
                (c_fmt       != pix_fmt_e'(pix_fmt)) ||
                (x_res       != width)        ||
                (y_res       != height)       ||
                (c_stride    != line_stride)  ||
                (c_offset    != start_offset) ||
                (c_size      != total_size);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_valid   <= 1'b0;
      mode_changed <= 1'b0;
      bytes_pp     <= '0;
      pix_fmt      <= '0;
      width        <= '0;
      height       <= '0;
      line_stride  <= '0;
      start_offset <= '0;
      total_size   <= '0;
    end else begin
      mode_valid   <= c_valid;
      mode_changed <= c_valid && c_differs;
      if (c_valid && c_differs) begin
        bytes_pp     <= c_bytes;
        pix_fmt      <= c_fmt;
        width        <= x_res;
        height       <= y_res;
        line_stride  <= c_stride;
        start_offset <= c_offset;
        total_size   <= c_size;
      end
    end
  end
endmodule

// File: rtl/fbm_checker.sv
`timescale 1ns/1ps
module fbm_checker #(
  parameter int DIM_W   = 16,
  parameter int ADDR_W  = 40,
  parameter int MIN_DIM = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_enable,
  input logic [ADDR_W-1:0] vmem_bytes,
  input logic              mode_valid,
  input logic [2:0]        bytes_pp,
  input logic [1:0]        pix_fmt,
  input logic [DIM_W-1:0]  width,
  input logic [DIM_W-1:0]  height,
  input logic [DIM_W+1:0]  line_stride,
  input logic [ADDR_W-1:0] start_offset,
  input logic [ADDR_W-1:0] total_size,
  input logic              mode_changed
);
  localparam int SW = DIM_W + 2;

  assert_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |=> !mode_valid);

  assert_rgb565_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_valid && pix_fmt == 2'd1) |-> bytes_pp == 3'd2);

  assert_xrgb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_valid && bytes_pp == 3'd4) |-> pix_fmt[1]);

  assert_known_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |-> (bytes_pp == 3'd2 || bytes_pp == 3'd4));

  assert_pitch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |-> line_stride >= (SW'(width) * SW'(bytes_pp)));

  assert_min_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |-> (width >= DIM_W'(MIN_DIM) && height >= DIM_W'(MIN_DIM)));

  assert_in_memory_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |-> ({1'b0, start_offset} + {1'b0, total_size}) <= {1'b0, $past(vmem_bytes)});

  assert_pulse_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_changed |-> mode_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_changed |-> ($stable(line_stride) && $stable(start_offset) &&
                       $stable(total_size) && $stable(width) && $stable(height)));
endmodule

bind fb_mode_decoder fbm_checker #(.DIM_W(DIM_W), .ADDR_W(ADDR_W), .MIN_DIM(MIN_DIM)) u_fbm_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctl_enable   (ctl_enable),
  .vmem_bytes   (vmem_bytes),
  .mode_valid   (mode_valid),
  .bytes_pp     (bytes_pp),
  .pix_fmt      (pix_fmt),
  .width        (width),
  .height       (height),
  .line_stride  (line_stride),
  .start_offset (start_offset),
  .total_size   (total_size),
  .mode_changed (mode_changed)
);

// File: tb/test_fb_mode_decoder.sv
`timescale 1ns/1ps
module test_fb_mode_decoder;
  localparam int DIM_W  = 16;
  localparam int ADDR_W = 40;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ctl_enable = 1'b0;
  logic [15:0]       bpp = '0;
  logic [DIM_W-1:0]  x_res = '0, y_res = '0, virt_width = '0, x_pan = '0, y_pan = '0;
  logic              fb_big_endian = 1'b0;
  logic [ADDR_W-1:0] vmem_bytes = '0;
  logic              mode_valid, mode_changed;
  logic [2:0]        bytes_pp;
  logic [1:0]        pix_fmt;
  logic [DIM_W-1:0]  width, height;
  logic [DIM_W+1:0]  line_stride;
  logic [ADDR_W-1:0] start_offset, total_size;

  always #2 clk = ~clk;

  fb_mode_decoder i_fb_mode_decoder (
    .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .bpp(bpp),
    .x_res(x_res), .y_res(y_res), .virt_width(virt_width), .x_pan(x_pan), .y_pan(y_pan),
    .fb_big_endian(fb_big_endian), .vmem_bytes(vmem_bytes),
    .mode_valid(mode_valid), .bytes_pp(bytes_pp), .pix_fmt(pix_fmt),
    .width(width), .height(height), .line_stride(line_stride),
    .start_offset(start_offset), .total_size(total_size), .mode_changed(mode_changed)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // bench model of the held mode
  longint h_bytes = 0, h_fmt = 0, h_w = 0, h_h = 0, h_stride = 0, h_ofs = 0, h_size = 0;
  longint e_valid, e_bytes, e_fmt, e_stride, e_ofs, e_size;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model(input bit en, input longint d, input longint x, input longint y,
                                input longint vw, input longint xo, input longint yo,
                                input bit be, input longint vm);
    longint eff;
    e_valid = en;
    e_bytes = (d == 16) ? 2 : (d == 32) ? 4 : 0;        // R2 R3
    e_fmt   = (d == 16) ? 1 : (d == 32) ? (be ? 3 : 2) : 0;
    if (e_bytes == 0) e_valid = 0;                       // R4
    eff      = (vw < x) ? x : vw;                        // R5
    e_stride = eff * e_bytes;
    e_size   = e_stride * y;                             // R6
    e_ofs    = xo * e_bytes + yo * e_stride;
    if (x < 64 || y < 64) e_valid = 0;                   // R7
    if (e_ofs + e_size > vm) e_valid = 0;                // R8
  endfunction

  task automatic run(input string req, input bit en, input int d, input int x, input int y,
                     input int vw, input int xo, input int yo, input bit be, input longint vm);
    bit differs;
    ctl_enable = en; bpp = 16'(d); x_res = DIM_W'(x); y_res = DIM_W'(y);
    virt_width = DIM_W'(vw); x_pan = DIM_W'(xo); y_pan = DIM_W'(yo);
    fb_big_endian = be; vmem_bytes = ADDR_W'(vm);
    model(en, d, x, y, vw, xo, yo, be, vm);
    @(posedge clk); #1;
    check(req, "valid", longint'(mode_valid), e_valid);
    if (e_valid != 0) begin
      differs = (e_bytes != h_bytes) || (e_fmt != h_fmt) || (x != h_w) || (y != h_h) ||
                (e_stride != h_stride) || (e_ofs != h_ofs) || (e_size != h_size);
      h_bytes = e_bytes; h_fmt = e_fmt; h_w = x; h_h = y;
      h_stride = e_stride; h_ofs = e_ofs; h_size = e_size;
      check("R10", "changed", longint'(mode_changed), longint'(differs));
    end else begin
      check("R11", "changed", longint'(mode_changed), 0);
    end
    // fields always equal the held mode (new if accepted, old if rejected: R11)
    check("R2", "bytes", longint'(bytes_pp), h_bytes);
    check("R3", "fmt", longint'(pix_fmt), h_fmt);
    check("R11", "width", longint'(width), h_w);
    check("R11", "height", longint'(height), h_h);
    check("R5", "stride", longint'(line_stride), h_stride);
    check("R6", "offset", longint'(start_offset), h_ofs);
    check("R6", "size", longint'(total_size), h_size);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int d, x, y, vw, xo, yo;
    bit en, be;
    longint vm;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check("R9", "reset valid", longint'(mode_valid), 0);
    check("R9", "reset offset", longint'(start_offset), 0);
    check("R9", "reset fmt", longint'(pix_fmt), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R9: input change is not visible before the next edge
    ctl_enable = 1; bpp = 16'd32; x_res = 16'd640; y_res = 16'd480; virt_width = 0;
    vmem_bytes = 40'd16777216;
    #1;
    check("R9", "before edge", longint'(mode_valid), 0);

    run("R3",  1, 32, 640, 480, 0, 0, 0, 0, 64'd16777216);
    run("R10", 1, 32, 640, 480, 0, 0, 0, 0, 64'd16777216);   // held: no pulse
    run("R3",  1, 32, 640, 480, 0, 0, 0, 1, 64'd16777216);   // BE
    run("R2",  1, 16, 800, 600, 1024, 3, 5, 0, 64'd16777216);
    run("R2",  1, 16, 800, 600, 1024, 3, 5, 1, 64'd16777216); // endian ignored
    run("R1",  0, 16, 800, 600, 1024, 3, 5, 0, 64'd16777216);
    run("R4",  1, 24, 800, 600, 0, 0, 0, 0, 64'd16777216);
    run("R4",  1, 8,  800, 600, 0, 0, 0, 0, 64'd16777216);
    run("R7",  1, 32, 63, 480, 0, 0, 0, 0, 64'd16777216);
    run("R7",  1, 32, 64, 63, 0, 0, 0, 0, 64'd16777216);
    run("R7",  1, 32, 64, 64, 0, 0, 0, 0, 64'd16777216);
    run("R5",  1, 32, 100, 100, 99, 0, 0, 0, 64'd16777216);
    run("R5",  1, 32, 100, 100, 101, 0, 0, 0, 64'd16777216);
    // R8: window ends exactly at top of memory, then one byte past
    run("R8",  1, 32, 256, 256, 256, 0, 0, 0, 64'd262144);
    run("R8",  1, 32, 256, 256, 256, 0, 0, 0, 64'd262143);
    run("R8",  1, 32, 256, 256, 256, 1, 0, 0, 64'd262147);
    run("R8",  1, 32, 256, 256, 256, 1, 0, 0, 64'd262148);
    // R6: large products need more than 32 bits
    run("R6",  1, 32, 65535, 65535, 65535, 65535, 65535, 0, 64'd1099511627775);
    run("R10", 1, 32, 640, 480, 0, 0, 0, 0, 64'd16777216);   // return to earlier mode

    void'($urandom(32'd4242));
    d = 32; x = 640; y = 480; vw = 0; xo = 0; yo = 0; en = 1; be = 0; vm = 64'd16777216;
    for (int i = 0; i < 600; i++) begin
      if (($urandom % 4) != 0) begin
        case ($urandom % 5)
          0: d = 16; 1: d = 32; 2: d = 16; 3: d = 32; default: d = 24;
        endcase
        en = ($urandom % 8) != 0;
        be = $urandom % 2;
        x  = 40 + int'($urandom % 1200);
        y  = 40 + int'($urandom % 1000);
        vw = int'($urandom % 2000);
        xo = int'($urandom % 300);
        yo = int'($urandom % 300);
        vm = 64'd1 << (20 + ($urandom % 5));
      end
      run("R6", en, d, x, y, vw, xo, yo, be, vm);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule